// File: doc/BRIEF.md
# I2S Master Audio Serial Port

This block is a clock-master stereo audio serial port for 16-bit samples. From the system clock it derives three clocks: a codec master clock at 256 times the sample rate, a bit clock at 32 times the sample rate, and a word-select clock at the sample rate. A single programmable divider sets the rate. The block can shift samples out, shift samples in, do both at once, or do neither. Each direction has an idle control of its own.

Each direction has a 32-entry half-word FIFO with a request output for an external DMA engine. Samples alternate left, right, left, right in both FIFOs. A small register-style write port sets the direction mode, the divider value, the per-direction idle and DMA-request enables, and the start bit. It also flushes the FIFOs. Software configures everything first and sets the start bit last. Writing zero to the control register stops the port.

The line format is standard I2S. Word select is low during the left slot. The MSB of a sample appears one bit-clock period after the word-select edge. Transmit data changes on the falling bit-clock edge, and receive data is sampled on the rising edge.

Top module: `i2s_master_port`

## Requirements
- R1: Register map. Address 0 is control: bit 0 start, bit 1 transmit idle, bit 2 receive idle. Address 1 is mode, bits [1:0]: bit 1 enables transmit and bit 0 enables receive (0 none, 1 receive only, 2 transmit only, 3 both). Address 2 is the divider value N. Address 3 is FIFO control: bit 0 transmit request enable, bit 1 receive request enable. While running with divider N, `cdclk` has a period of 2(N+1) system clocks, `sclk` a period of 16(N+1), and `lrck` a period of 512(N+1).
- R2: `lrck` is low for the left slot and high for the right slot. Each slot lasts 16 bit-clock periods. `lrck` changes only together with a falling `sclk` edge.
- R3: Transmit samples are popped in FIFO order, left first. Each sample is sent MSB first. The MSB is driven in the bit period that starts one falling `sclk` edge after the `lrck` edge, and the LSB in the first bit period of the following slot. `sdo` changes only together with a falling `sclk` edge.
- R4: `sdi` is sampled in the system-clock cycle before each rising `sclk` edge. It is assembled with the same alignment as R3, and each completed word is pushed into the receive FIFO in arrival order. `rx_data` shows the oldest entry.
- R5: When the transmit FIFO is empty at the start of a slot, that slot carries an all-zero sample.
- R6: A received word that finds the receive FIFO full is dropped and sets `rx_ovf`. `rx_ovf` stays set until a flush.
- R7: A direction that the mode field leaves out does not touch its FIFO. An unused transmitter holds `sdo` low, and an unused receiver pushes nothing.
- R8: Setting a direction's idle bit has the same effect as leaving that direction out of the mode field.
- R9: No clock or serial activity occurs until the start bit is set. After the control register is written with start cleared, `cdclk`, `sclk`, `lrck` and `sdo` return low within two cycles and stay low. After reset all outputs are low.
- R10: Writing the value zero to FIFO control empties both FIFOs and clears `rx_ovf`.
- R11: `tx_req` is high exactly when the transmit request enable is set and the transmit FIFO holds fewer than 32 entries. `rx_req` is high exactly when the receive request enable is set and the receive FIFO is not empty.
- R12: `tx_level` and `rx_level` report the entry counts. A push into a full transmit FIFO and a pop from an empty receive FIFO are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| tx_push | input | 1 | Push one half-word into the transmit FIFO |
| tx_data | input | 16 | Transmit half-word |
| tx_req | output | 1 | Transmit DMA request |
| tx_level | output | 6 | Transmit FIFO entry count |
| rx_pop | input | 1 | Pop one half-word from the receive FIFO |
| rx_data | output | 16 | Oldest receive half-word |
| rx_req | output | 1 | Receive DMA request |
| rx_level | output | 6 | Receive FIFO entry count |
| rx_ovf | output | 1 | Sticky receive overflow flag |
| cdclk | output | 1 | Codec master clock, 256 fs |
| sclk | output | 1 | Bit clock, 32 fs |
| lrck | output | 1 | Word select, low for left |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The bench loops `sdo` back to `sdi` and checks that the received words match the pushed ones in order. A one-bit slip in the MSB alignment, or a swap of left and right, would corrupt every returned word. Once the pushed samples run out, the returned words must be zero. A design that repeated the last sample on underrun would return stale data instead. A run with the receiver alone, fed random serial data, fills the receive FIFO past its depth. This catches a design that overwrites old entries, or that clears the overflow flag before a flush. The bench also checks idle and mode masking, where a leaky design would drain the transmit FIFO. It checks that stopping returns every clock low, and it measures the clock periods at more than one divider value.

// File: rtl/i2s_port_pkg.sv
package i2s_port_pkg;
  localparam int SAMPLE_W = 16;
  localparam int FRAME_W  = 9;

  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_MODE  = 2'd1,
    A_PRESC = 2'd2,
    A_FIFO  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic rx_idle;
    logic tx_idle;
    logic start;
  } ctrl_t;

  typedef struct packed {
    logic rx_dma;
    logic tx_dma;
  } dma_t;
endpackage

// File: rtl/i2s_clkgen.sv
module i2s_clkgen #(
  parameter int PW = 5,
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] presc,
  output logic          fall_ev,
  output logic          rise_ev,
  output logic [3:0]    slot_now,
  output logic [3:0]    slot_next,
  output logic          cdclk,
  output logic          sclk,
  output logic          lrck
);
  logic [PW-1:0] pc_q, pc_d;
  logic [CW-1:0] cnt_q, cnt_d, cnt_inc;
  logic          tick;

  always_comb begin
    tick      = run && (pc_q == presc);
    cnt_inc   = cnt_q + 1'b1;
    fall_ev   = tick && (cnt_q[3:0] == 4'hF);
    rise_ev   = tick && (cnt_q[3:0] == 4'h7);
    slot_now  = cnt_q[7:4];
    slot_next = cnt_inc[7:4];
    pc_d      = pc_q;
    cnt_d     = cnt_q;
    if (!run) begin
      pc_d  = '0;
      cnt_d = '0;
    end else if (tick) begin
      pc_d  = '0;
      cnt_d = cnt_inc;
    end else begin
      pc_d  = pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      cnt_q <= '0;
    end else begin
      pc_q  <= pc_d;
      cnt_q <= cnt_d;
    end
  end

  assign cdclk = cnt_q[0];
  assign sclk  = cnt_q[3];
  assign lrck  = cnt_q[CW-1];
endmodule

// File: rtl/i2s_fifo.sv
module i2s_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          do_push, do_pop;

  always_comb begin
    full    = (lvl_q == LW'(DEPTH));
    empty   = (lvl_q == '0);
    do_push = push && !full;
    do_pop  = pop && !empty;
    wp_d    = wp_q;
    rp_d    = rp_q;
    lvl_d   = lvl_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      lvl_d = '0;
    end else begin
      if (do_push) wp_d = (wp_q == LAST_IDX) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_d = (rp_q == LAST_IDX) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   lvl_d = lvl_q + 1'b1;
        2'b01:   lvl_d = lvl_q - 1'b1;
        default: lvl_d = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp_q] <= din;
  end

  assign dout  = mem[rp_q];
  assign level = lvl_q;
endmodule

// File: rtl/i2s_serdes.sv
module i2s_serdes #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tx_act,
  input  logic         rx_act,
  input  logic         fall_ev,
  input  logic         rise_ev,
  input  logic [3:0]   slot_now,
  input  logic [3:0]   slot_next,
  input  logic         tx_empty,
  input  logic [W-1:0] tx_head,
  input  logic         sdi,
  output logic         tx_pop,
  output logic         sdo,
  output logic         rx_push,
  output logic [W-1:0] rx_word
);
  localparam logic [3:0] MSB_SLOT = 4'd1;
  localparam logic [3:0] LSB_SLOT = 4'd0;

  logic [W-1:0] tsh_q, tsh_d, rsh_q, rsh_d, rx_cat;
  logic         arm_q, arm_d;

  always_comb begin
    rx_cat  = {rsh_q[W-2:0], sdi};
    tx_pop  = fall_ev && tx_act && (slot_next == MSB_SLOT) && !tx_empty;
    rx_push = rise_ev && rx_act && arm_q && (slot_now == LSB_SLOT);

    tsh_d = tsh_q;
    if (!run) begin
      tsh_d = '0;
    end else if (fall_ev) begin
      if (!tx_act)                    tsh_d = '0;
      else if (slot_next == MSB_SLOT) tsh_d = tx_empty ? '0 : tx_head;
      else                            tsh_d = {tsh_q[W-2:0], 1'b0};
    end

    rsh_d = (rise_ev && rx_act) ? rx_cat : rsh_q;

    arm_d = arm_q;
    if (!rx_act)                               arm_d = 1'b0;
    else if (rise_ev && slot_now == MSB_SLOT)  arm_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsh_q <= '0;
      rsh_q <= '0;
      arm_q <= 1'b0;
    end else begin
      tsh_q <= tsh_d;
      rsh_q <= rsh_d;
      arm_q <= arm_d;
    end
  end

  assign sdo     = tsh_q[W-1];
  assign rx_word = rx_cat;
endmodule

// File: rtl/i2s_master_port.sv
module i2s_master_port
  import i2s_port_pkg::*;
#(
  parameter int  DEPTH = 32,
  parameter int  PW    = 5,
  parameter int  DW    = 8,
  localparam int LW    = $clog2(DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [DW-1:0]       wr_data,
  input  logic                tx_push,
  input  logic [SAMPLE_W-1:0] tx_data,
  output logic                tx_req,
  output logic [LW-1:0]       tx_level,
  input  logic                rx_pop,
  output logic [SAMPLE_W-1:0] rx_data,
  output logic                rx_req,
  output logic [LW-1:0]       rx_level,
  output logic                rx_ovf,
  output logic                cdclk,
  output logic                sclk,
  output logic                lrck,
  output logic                sdo,
  input  logic                sdi
);
  logic [1:0]          rs_q;
  logic                rst_i;
  ctrl_t               ctrl_q, ctrl_d;
  logic [1:0]          mode_q, mode_d;
  logic [PW-1:0]       presc_q, presc_d;
  dma_t                dma_q, dma_d;
  logic                ovf_q, ovf_d;
  logic                flush, run, tx_act, rx_act;
  logic                fall_ev, rise_ev;
  logic [3:0]          slot_now, slot_next;
  logic                tx_pop, tx_empty, tx_full;
  logic [SAMPLE_W-1:0] tx_head;
  logic                rx_push, rx_empty, rx_full;
  logic [SAMPLE_W-1:0] rx_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  always_comb begin
    ctrl_d  = ctrl_q;
    mode_d  = mode_q;
    presc_d = presc_q;
    dma_d   = dma_q;
    flush   = 1'b0;
    if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        A_CTRL:  ctrl_d  = ctrl_t'(wr_data[2:0]);
        A_MODE:  mode_d  = wr_data[1:0];
        A_PRESC: presc_d = wr_data[PW-1:0];
        default: begin
          dma_d = dma_t'(wr_data[1:0]);
          flush = (wr_data == '0);
        end
      endcase
    end
    ovf_d = flush ? 1'b0 : (ovf_q | (rx_push & rx_full));
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctrl_q  <= '0;
      mode_q  <= '0;
      presc_q <= '0;
      dma_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      mode_q  <= mode_d;
      presc_q <= presc_d;
      dma_q   <= dma_d;
      ovf_q   <= ovf_d;
    end
  end

  assign run    = ctrl_q.start;
  assign tx_act = run & mode_q[1] & ~ctrl_q.tx_idle;
  assign rx_act = run & mode_q[0] & ~ctrl_q.rx_idle;

  i2s_clkgen #(.PW(PW), .CW(FRAME_W)) u_clk (
    .clk(clk), .rst_n(rst_i), .run(run), .presc(presc_q),
    .fall_ev(fall_ev), .rise_ev(rise_ev),
    .slot_now(slot_now), .slot_next(slot_next),
    .cdclk(cdclk), .sclk(sclk), .lrck(lrck)
  );

  i2s_serdes #(.W(SAMPLE_W)) u_sd (
    .clk(clk), .rst_n(rst_i), .run(run), .tx_act(tx_act), .rx_act(rx_act),
    .fall_ev(fall_ev), .rise_ev(rise_ev),
    .slot_now(slot_now), .slot_next(slot_next),
    .tx_empty(tx_empty), .tx_head(tx_head), .sdi(sdi),
    .tx_pop(tx_pop), .sdo(sdo), .rx_push(rx_push), .rx_word(rx_word)
  );

  i2s_fifo #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_i), .flush(flush),
    .push(tx_push), .din(tx_data), .pop(tx_pop), .dout(tx_head),
    .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  i2s_fifo #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_i), .flush(flush),
    .push(rx_push), .din(rx_word), .pop(rx_pop), .dout(rx_data),
    .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  assign tx_req = dma_q.tx_dma & ~tx_full;
  assign rx_req = dma_q.rx_dma & ~rx_empty;
  assign rx_ovf = ovf_q;
endmodule

// File: rtl/i2s_master_port_chk.sv
module i2s_master_port_chk #(
  parameter int DEPTH = 32,
  parameter int LW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          flush,
  input logic          cdclk,
  input logic          sclk,
  input logic          lrck,
  input logic          sdo,
  input logic          tx_req,
  input logic          rx_req,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic          rx_ovf
);
  // R9: a stopped port brings all clocks low on the next cycle
  p_stop_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!cdclk && !sclk && !lrck));

  // R2: word select only moves with a falling bit clock
  p_lrck_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$stable(lrck)) |-> $fell(sclk));

  // R3: serial data only moves with a falling bit clock
  p_sdo_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$stable(sdo)) |-> $fell(sclk));

  // R6: overflow flag is sticky until a flush
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovf && !flush) |=> rx_ovf);

  // R10: a flush empties both FIFOs and clears the flag
  p_flush_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (rx_ovf == 1'b0 && tx_level == '0 && rx_level == '0));

  // R11: requests only with room or data
  p_txreq_room_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> (tx_level < LW'(DEPTH)));
  p_rxreq_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req |-> (rx_level != '0));

  // R12: counts never exceed the depth
  p_level_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH)));
endmodule

bind i2s_master_port i2s_master_port_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .flush(flush),
  .cdclk(cdclk), .sclk(sclk), .lrck(lrck), .sdo(sdo),
  .tx_req(tx_req), .rx_req(rx_req),
  .tx_level(tx_level), .rx_level(rx_level), .rx_ovf(rx_ovf)
);

// File: tb/sim_i2s_master_port.sv
module sim_i2s_master_port;
  localparam int DEPTH = 32;
  localparam int LW    = 6;

  logic        clk, rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [7:0]  wr_data;
  logic        tx_push, rx_pop;
  logic [15:0] tx_data, rx_data;
  logic        tx_req, rx_req, rx_ovf;
  logic [LW-1:0] tx_level, rx_level;
  logic        cdclk, sclk, lrck, sdo;
  logic        loop, pat;
  logic [15:0] lfsr;
  wire         sdi = loop ? sdo : pat;

  i2s_master_port u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_push(tx_push), .tx_data(tx_data), .tx_req(tx_req), .tx_level(tx_level),
    .rx_pop(rx_pop), .rx_data(rx_data), .rx_req(rx_req), .rx_level(rx_level),
    .rx_ovf(rx_ovf), .cdclk(cdclk), .sclk(sclk), .lrck(lrck), .sdo(sdo), .sdi(sdi)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit          m_start, m_txi, m_rxi, m_txd, m_rxd, m_ovf, m_arm;
  int          m_mode, m_presc, m_pc, m_cnt;
  logic [15:0] m_sh, m_rsh;
  logic [15:0] m_txq[$];
  logic [15:0] m_rxq[$];

  task automatic step();
    int          txsz0 = m_txq.size();
    int          rxsz0 = m_rxq.size();
    int          c0    = m_cnt;
    bit          tick  = m_start && (m_pc == m_presc);
    bit          fall  = tick && (c0 % 16 == 15);
    bit          rise  = tick && (c0 % 16 == 7);
    bit          txa   = m_start && ((m_mode >> 1) & 1) && !m_txi;
    bit          rxa   = m_start && (m_mode & 1) && !m_rxi;
    int          snext = ((c0 + 1) / 16) % 16;
    int          snow  = (c0 / 16) % 16;
    logic [15:0] w;
    if (!m_start) begin m_pc = 0; m_cnt = 0; end
    else if (tick) begin m_pc = 0; m_cnt = (c0 + 1) % 512; end
    else m_pc++;
    if (!m_start) m_sh = 0;
    else if (fall) begin
      if (!txa) m_sh = 0;
      else if (snext == 1) m_sh = (txsz0 > 0) ? m_txq.pop_front() : 16'h0;
      else m_sh = m_sh << 1;
    end
    if (rise && rxa) begin
      w = {m_rsh[14:0], sdi};
      if (snow == 0 && m_arm) begin
        if (rxsz0 < DEPTH) m_rxq.push_back(w);
        else m_ovf = 1;
      end
      m_rsh = w;
    end
    if (!rxa) m_arm = 0;
    else if (rise && snow == 1) m_arm = 1;
    if (tx_push && txsz0 < DEPTH) m_txq.push_back(tx_data);
    if (rx_pop && rxsz0 > 0) void'(m_rxq.pop_front());
    if (wr_en) begin
      case (wr_addr)
        2'd0: begin m_start = wr_data[0]; m_txi = wr_data[1]; m_rxi = wr_data[2]; end
        2'd1: m_mode = wr_data[1:0];
        2'd2: m_presc = wr_data[4:0];
        default: begin
          m_txd = wr_data[0]; m_rxd = wr_data[1];
          if (wr_data == 8'h00) begin m_txq.delete(); m_rxq.delete(); m_ovf = 0; end
        end
      endcase
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_start = 0; m_txi = 0; m_rxi = 0; m_txd = 0; m_rxd = 0; m_ovf = 0; m_arm = 0;
      m_mode = 0; m_presc = 0; m_pc = 0; m_cnt = 0; m_sh = 0; m_rsh = 0;
      m_txq.delete(); m_rxq.delete();
    end else step();
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 cdclk", cdclk, m_cnt % 2);
      chk("R1 sclk", sclk, (m_cnt >> 3) & 1);
      chk("R2 lrck", lrck, (m_cnt >> 8) & 1);
      chk("R3 sdo", sdo, m_sh[15]);
      chk("R12 tx_level", tx_level, m_txq.size());
      chk("R4 rx_level", rx_level, m_rxq.size());
      if (m_rxq.size() > 0) chk("R4 rx_data", rx_data, m_rxq[0]);
      chk("R6 rx_ovf", rx_ovf, m_ovf);
      chk("R11 tx_req", tx_req, (m_txd && m_txq.size() < DEPTH) ? 1 : 0);
      chk("R11 rx_req", rx_req, (m_rxd && m_rxq.size() > 0) ? 1 : 0);
    end
  end

  // random serial source
  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin lfsr <= 16'hACE1; pat <= 1'b0; end
    else begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pat  <= lfsr[0];
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[7:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push_tx(input logic [15:0] v);
    @(negedge clk);
    tx_push = 1'b1; tx_data = v;
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic pop_rx(output logic [15:0] v);
    @(negedge clk);
    v = rx_data; rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  function automatic bit pick(input int w);
    case (w)
      0:       return cdclk;
      1:       return sclk;
      default: return lrck;
    endcase
  endfunction

  task automatic period(input int w, output int p);
    int c = 0;
    do @(negedge clk); while (pick(w) != 1'b0);
    do @(negedge clk); while (pick(w) != 1'b1);
    do begin @(negedge clk); c++; end while (pick(w) != 1'b0);
    do begin @(negedge clk); c++; end while (pick(w) != 1'b1);
    p = c;
  endtask

  function automatic logic [15:0] sample(input int i);
    return 16'h8001 + 16'(i * 16'h1357);
  endfunction

  // ---------------- scenario ----------------
  initial begin
    int p;
    logic [15:0] v;
    wr_en = 0; wr_addr = 0; wr_data = 0; tx_push = 0; tx_data = 0; rx_pop = 0; loop = 1'b1;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(5);
    // R9: reset state
    chk("R9 reset sclk", sclk, 0);
    chk("R9 reset lrck", lrck, 0);
    chk("R9 reset sdo", sdo, 0);
    chk("R11 reset tx_req", tx_req, 0);

    // R11/R12: fill transmit FIFO while stopped
    wr(3, 1);
    chk("R11 tx_req with room", tx_req, 1);
    for (int i = 0; i < 34; i++) push_tx(sample(i));
    idle(1);
    chk("R12 tx_level saturates", tx_level, DEPTH);
    chk("R11 tx_req when full", tx_req, 0);
    chk("R9 no activity before start", sclk, 0);

    // R10: flush
    wr(3, 0);
    idle(1);
    chk("R10 tx flushed", tx_level, 0);

    // R3/R4/R5/R1: loopback at N=1
    wr(2, 1);
    wr(1, 3);
    wr(3, 3);
    for (int i = 0; i < 8; i++) push_tx(sample(i));
    wr(0, 1);
    period(0, p); chk("R1 cdclk period N=1", p, 4);
    period(1, p); chk("R1 sclk period N=1", p, 32);
    period(2, p); chk("R1 lrck period N=1", p, 1024);
    idle(4096);
    wr(0, 0);
    idle(3);
    chk("R9 stop cdclk", cdclk, 0);
    chk("R9 stop sclk", sclk, 0);
    chk("R9 stop lrck", lrck, 0);
    chk("R5 enough words", (rx_level >= 10) ? 1 : 0, 1);
    for (int i = 0; i < 8; i++) begin
      pop_rx(v);
      chk($sformatf("R3 R4 loopback word %0d", i), v, sample(i));
    end
    for (int i = 0; i < 2; i++) begin
      pop_rx(v);
      chk("R5 underrun sends zero", v, 0);
    end
    idle(100);
    chk("R9 stays stopped", sclk, 0);

    // R1 at N=0, R7: transmit only
    wr(3, 0);
    wr(2, 0);
    wr(1, 2);
    for (int i = 0; i < 4; i++) push_tx(sample(20 + i));
    wr(0, 1);
    period(1, p); chk("R1 sclk period N=0", p, 16);
    idle(1200);
    chk("R7 tx-only drains tx", tx_level, 0);
    chk("R7 tx-only receives nothing", rx_level, 0);
    wr(0, 0);

    // R8: transmit idle while receive runs
    wr(3, 0);
    wr(1, 3);
    for (int i = 0; i < 4; i++) push_tx(sample(40 + i));
    wr(0, 3);
    idle(1100);
    wr(0, 0);
    idle(3);
    chk("R8 tx idle keeps FIFO", tx_level, 4);
    chk("R8 receiver still runs", (rx_level >= 2) ? 1 : 0, 1);
    pop_rx(v);
    chk("R8 idle transmitter sends low", v, 0);

    // R6: receive overflow with random data
    wr(3, 0);
    loop = 1'b0;
    wr(1, 1);
    wr(3, 2);
    wr(0, 1);
    idle(9800);
    chk("R6 overflow set", rx_ovf, 1);
    chk("R6 FIFO holds depth", rx_level, DEPTH);
    chk("R11 rx_req with data", rx_req, 1);
    wr(0, 0);
    idle(50);
    chk("R6 overflow sticky", rx_ovf, 1);
    wr(3, 0);
    idle(1);
    chk("R10 overflow cleared", rx_ovf, 0);
    chk("R10 rx flushed", rx_level, 0);

    // R12: pop from empty is ignored
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
    idle(1);
    chk("R12 pop empty ignored", rx_level, 0);

    idle(10);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule